// File: doc/BRIEF.md
# Dual-Clock FIFO with Per-Side Fill Levels

This block moves a stream of words from a producer running on one clock to a consumer running on a second, unrelated clock. Words are stored in a power-of-two array. The write side and the read side each keep their own pointer. Each pointer is handed to the opposite domain in Gray code through a two-register synchroniser, so only one bit changes at a time as it crosses.

Both sides report a fill level that is one bit wider than the address, so it covers every value from empty to completely full. A side sees its own transfers one clock after they are accepted. When both sides share a clock, a side sees the other side's transfers two clocks later than that.

Both ports are valid/ready streams. On the write side, a word is taken on a rising write-clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the write-side level equals the depth; the producer may hold `wr_valid` and `wr_data` while it waits. On the read side, `rd_valid` is high whenever the read-side level is non-zero, and `rd_data` then shows the oldest word. A word is removed on a rising read-clock edge where `rd_valid` and `rd_ready` are both high. A single asynchronous active-low reset clears both sides.

Top module: `xcf_fifo`

## Requirements
- R1: While and after reset (`rst_n` low), `wr_level` and `rd_level` are 0, `rd_valid` is 0 and `wr_ready` is 1.
- R2: An accepted write (`wr_valid` and `wr_ready` high at a write-clock edge) raises `wr_level` by one, visible right after that edge. Without an accepted write, `wr_level` never rises.
- R3: An accepted read (`rd_valid` and `rd_ready` high at a read-clock edge) lowers `rd_level` by one, visible right after that edge. Without an accepted read, `rd_level` never falls.
- R4: With both clocks tied together, a write appears in `rd_level` two edges after it appears in `wr_level`, and a read appears in `wr_level` two edges after it appears in `rd_level`.
- R5: `wr_ready` is 0 exactly when `wr_level` equals the depth (2^L2D, 16 by default). A write offered while `wr_ready` is 0 is dropped and changes no level.
- R6: `rd_valid` is 1 exactly when `rd_level` is non-zero. A read offered while `rd_valid` is 0 changes no level.
- R7: While `rd_valid` is 1, `rd_data` shows the oldest unread word and holds it until that word is read. Words come out in write order with none lost or repeated, including when the two clocks are unrelated.
- R8: Neither level ever exceeds the depth.
- R9: The Gray-coded pointer each side sends to the other domain changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Write-side clock |
| wr_data | input | DW | Word offered for writing |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word (not full) |
| wr_level | output | L2D+1 | Write-side fill level |
| rd_clk | input | 1 | Read-side clock |
| rd_data | output | DW | Oldest stored word |
| rd_valid | output | 1 | A word is available (not empty) |
| rd_ready | input | 1 | Consumer takes the word on `rd_data` |
| rd_level | output | L2D+1 | Read-side fill level |

## Verification
With both sides on one clock, a bench model predicts both levels, `wr_ready` and `rd_valid` on every edge. The model uses the one-edge and three-edge delays, so any change in synchroniser depth or pointer timing shows up as a level mismatch. A directed fill past full, followed by a drain past empty, separates a correct discard of blocked transfers from a pointer that wraps. A long random mix of writes and reads then exercises the level arithmetic across the pointer wrap. A second phase uses unrelated clock periods and checks only word order and completeness, plus the final return of both levels to zero, because that is the property that survives asynchronous skew.

// File: rtl/xcf_pkg.sv
package xcf_pkg;
  // Number of capture registers on each pointer crossing.
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  import xcf_pkg::*;

  logic [W-1:0] stg [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[SYNC_STAGES-1];
endmodule

// File: rtl/xcf_gray2bin.sv
module xcf_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  assign bin[W-1] = gray[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_bit
    assign bin[i] = bin[i+1] ^ gray[i];
  end
endmodule

// File: rtl/xcf_ram.sv
module xcf_ram #(
  parameter int DW  = 8,
  parameter int L2D = 4
) (
  input  logic           wclk,
  input  logic           we,
  input  logic [L2D-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [L2D-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << L2D;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xcf_port.sv
// One side of the FIFO. IS_WR selects the write-side flag (not full)
// or the read-side flag (not empty) and the sign of the level difference.
module xcf_port #(
  parameter int L2D   = 4,
  parameter bit IS_WR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [L2D:0] far_gray,
  output logic         flag,
  output logic         xfer,
  output logic [L2D:0] level,
  output logic [L2D-1:0] addr,
  output logic [L2D:0] own_gray
);
  localparam int PW = L2D + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << L2D);

  logic [PW-1:0] own_bin, own_nxt, far_sync, far_bin;

  xcf_sync #(.W(PW)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (far_gray),
    .q (far_sync)
  );

  xcf_gray2bin #(.W(PW)) u_g2b (
    .gray (far_sync),
    .bin (far_bin)
  );

  if (IS_WR) begin : g_wr
    assign level = own_bin - far_bin;
    assign flag  = (level != DEPTH);
  end else begin : g_rd
    assign level = far_bin - own_bin;
    assign flag  = (level != '0);
  end

  assign xfer    = req & flag;
  assign own_nxt = own_bin + PW'(xfer);
  assign addr    = own_bin[L2D-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_bin  <= '0;
      own_gray <= '0;
    end else begin
      own_bin  <= own_nxt;
      own_gray <= own_nxt ^ (own_nxt >> 1);
    end
  end
endmodule

// File: rtl/xcf_fifo.sv
module xcf_fifo #(
  parameter int DW  = 8,
  parameter int L2D = 4
) (
  input  logic          rst_n,
  input  logic          wr_clk,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [L2D:0]  wr_level,
  input  logic          rd_clk,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [L2D:0]  rd_level
);
  logic [L2D:0]   wgray, rgray;
  logic [L2D-1:0] waddr, raddr;
  logic           push, pop;

  xcf_port #(.L2D(L2D), .IS_WR(1'b1)) u_wside (
    .clk (wr_clk),
    .rst_n (rst_n),
    .req (wr_valid),
    .far_gray (rgray),
    .flag (wr_ready),
    .xfer (push),
    .level (wr_level),
    .addr (waddr),
    .own_gray (wgray)
  );

  xcf_port #(.L2D(L2D), .IS_WR(1'b0)) u_rside (
    .clk (rd_clk),
    .rst_n (rst_n),
    .req (rd_ready),
    .far_gray (wgray),
    .flag (rd_valid),
    .xfer (pop),
    .level (rd_level),
    .addr (raddr),
    .own_gray (rgray)
  );

  xcf_ram #(.DW(DW), .L2D(L2D)) u_ram (
    .wclk (wr_clk),
    .we (push),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/xcf_fifo_chk.sv
module xcf_fifo_chk #(
  parameter int DW  = 8,
  parameter int L2D = 4
) (
  input logic          rst_n,
  input logic          wr_clk,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [L2D:0]  wr_level,
  input logic          rd_clk,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [L2D:0]  rd_level,
  input logic [L2D:0]  wgray,
  input logic [L2D:0]  rgray
);
  localparam logic [L2D:0] DEPTH = (L2D+1)'(1 << L2D);

  // R2
  p_wr_no_rise_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> wr_level <= $past(wr_level));
  // R3
  p_rd_no_fall_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> rd_level >= $past(rd_level));
  // R5
  p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_level == DEPTH) |-> !wr_ready);
  // R6
  p_no_underflow_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_level == '0) |-> !rd_valid);
  // R7
  p_head_hold_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R8
  p_wr_bound_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_level <= DEPTH);
  p_rd_bound_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_level <= DEPTH);
  // R9
  p_wgray_step_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_rgray_step_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind xcf_fifo xcf_fifo_chk #(.DW(DW), .L2D(L2D)) u_chk (
  .rst_n (rst_n),
  .wr_clk (wr_clk),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_level (wr_level),
  .rd_clk (rd_clk),
  .rd_data (rd_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_level (rd_level),
  .wgray (wgray),
  .rgray (rgray)
);

// File: tb/xcf_fifo_test.sv
module xcf_fifo_test;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 13;
  localparam int DW    = 8;
  localparam int L2D   = 4;
  localparam int DEPTH = 1 << L2D;
  localparam int NASYNC = 400;
  localparam int WDOG  = 100000;

  logic clk = 1'b0, rclk_free = 1'b0, same_clk = 1'b1;
  logic rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_valid = 1'b0, rd_ready = 1'b0;
  logic wr_ready, rd_valid;
  logic [L2D:0] wr_level, rd_level;
  logic [DW-1:0] rd_data;
  logic rd_clk;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(RCLK_PERIOD/2) rclk_free = ~rclk_free;
  assign rd_clk = same_clk ? clk : rclk_free;

  xcf_fifo #(.DW(DW), .L2D(L2D)) uut (
    .rst_n (rst_n), .wr_clk (clk), .wr_data (wr_data), .wr_valid (wr_valid),
    .wr_ready (wr_ready), .wr_level (wr_level), .rd_clk (rd_clk),
    .rd_data (rd_data), .rd_valid (rd_valid), .rd_ready (rd_ready),
    .rd_level (rd_level)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] q[$];
  int w0, w1, w2, r0, r1, r2;
  int rd_count;
  logic done = 1'b0;

  function automatic int exp_wl();  return w0 - r2; endfunction
  function automatic int exp_rl();  return w2 - r0; endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "wr_level", int'(wr_level), exp_wl());
    chk("R4", "rd_level", int'(rd_level), exp_rl());
    chk("R5", "wr_ready", int'(wr_ready), int'(exp_wl() != DEPTH));
    chk("R6", "rd_valid", int'(rd_valid), int'(exp_rl() != 0));
  endtask

  // One lockstep cycle; called at a negedge with outputs settled.
  task automatic step(input logic wv, input logic rv);
    logic aw, ar;
    check_all();
    aw = wv && (exp_wl() != DEPTH);
    ar = rv && (exp_rl() != 0);
    if (ar) begin
      chk("R7", "rd_data", int'(rd_data), int'(q[0]));
      void'(q.pop_front());
    end
    wr_valid = wv;
    rd_ready = rv;
    wr_data  = DW'($urandom);
    if (aw) q.push_back(wr_data);
    w2 = w1; w1 = w0; w0 += int'(aw);
    r2 = r1; r1 = r0; r0 += int'(ar);
    @(negedge clk);
  endtask

  task automatic check_reset();
    chk("R1", "wr_level", int'(wr_level), 0);
    chk("R1", "rd_level", int'(rd_level), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "wr_ready", int'(wr_ready), 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    w0 = 0; w1 = 0; w2 = 0; r0 = 0; r1 = 0; r2 = 0;
    #(CLK_PERIOD*3);
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();

    // Single write then idle: R2 immediately, R4 two edges later.
    step(1'b1, 1'b0);
    chk("R2", "wr_level after one write", int'(wr_level), 1);
    chk("R4", "rd_level not yet", int'(rd_level), 0);
    repeat (3) step(1'b0, 1'b0);
    chk("R4", "rd_level after delay", int'(rd_level), 1);
    // Single read: R3 then R4 on the write side.
    step(1'b0, 1'b1);
    chk("R3", "rd_level after read", int'(rd_level), 0);
    repeat (3) step(1'b0, 1'b0);

    // Fill past full: R5 drops excess writes.
    repeat (DEPTH + 6) step(1'b1, 1'b0);
    chk("R5", "wr_ready at full", int'(wr_ready), 0);
    chk("R5", "wr_level at full", int'(wr_level), DEPTH);
    repeat (3) step(1'b0, 1'b0);
    // Drain past empty: R6 ignores extra reads.
    repeat (DEPTH + 6) step(1'b0, 1'b1);
    chk("R6", "rd_valid at empty", int'(rd_valid), 0);
    chk("R6", "rd_level at empty", int'(rd_level), 0);
    repeat (3) step(1'b0, 1'b0);

    // Random mixes with different biases.
    for (int i = 0; i < 600; i++)
      step(($urandom % 100) < 65, ($urandom % 100) < 45);
    for (int i = 0; i < 600; i++)
      step(($urandom % 100) < 40, ($urandom % 100) < 70);
    for (int i = 0; i < 400; i++)
      step($urandom % 2 == 1, $urandom % 2 == 1);
    repeat (4) step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // Unrelated clocks.
    wr_valid = 1'b0; rd_ready = 1'b0;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    check_reset();
    same_clk = 1'b0;
    q.delete();
    rd_count = 0;
    #(CLK_PERIOD*3);
    @(negedge clk);
    rst_n = 1'b1;
    fork
      begin : writer
        int sent;
        sent = 0;
        while (sent < NASYNC) begin
          @(negedge clk);
          if (wr_valid && wr_ready) sent++;
          if (sent < NASYNC) begin
            if (!wr_valid || wr_ready) begin
              wr_valid = ($urandom % 100) < 60;
              wr_data  = DW'($urandom);
              if (wr_valid) q.push_back(wr_data);
            end
          end else wr_valid = 1'b0;
        end
      end
      begin : reader
        while (rd_count < NASYNC) begin
          @(negedge rd_clk);
          rd_ready = ($urandom % 100) < 55;
          if (rd_ready && rd_valid) begin
            chk("R7", "async order", int'(rd_data), int'(q[0]));
            void'(q.pop_front());
            rd_count++;
          end
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
      end
    join
    repeat (8) @(negedge clk);
    chk("R7", "async count", rd_count, NASYNC);
    chk("R3", "async rd_level drained", int'(rd_level), 0);
    chk("R2", "async wr_level drained", int'(wr_level), 0);
    chk("R6", "async rd_valid drained", int'(rd_valid), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule